// File: doc/BRIEF.md
# PWM Carrier with Cycle-by-Cycle Current Limit

This block produces one complementary pair of gate-drive signals from a programmable carrier counter. The counter runs as a rising sawtooth, a falling sawtooth or a triangle. A prescaler and a period value set the carrier frequency. The high-side request is active while the carrier count is below an 11-bit duty value. The duty value is written through a strobe and is held in a shadow register until the next carrier period begins. Each output rises only after a programmable dead time, so the two gate signals are never driven high together.

Three digital over-current inputs come from external comparators: positive over-current, negative over-current and short. When any of them is high, both gate signals are forced low on the next clock. They stay low for the rest of the carrier period and are released when the next period starts. A short also sets a sticky fault flag, which software clears with a strobe.

The block also sends event pulses to the rest of the chip. A one-clock strobe marks each period start. A second one-clock pulse serves as the ADC trigger, placed either at the carrier peak or at the carrier valley.

Top module: `pwm_carrier_cbc`

## Requirements
- R1: `mode_i` selects the carrier shape: 0 is a rising sawtooth, 1 a falling sawtooth, 2 a triangle, and 3 behaves as 0. With period value P, a sawtooth period lasts P+1 counter steps and a triangle period lasts 2*P steps.
- R2: The counter advances once every `prescale_i`+1 clocks, so each period lasts (`prescale_i`+1) times the number of steps given in R1.
- R3: The duty value is {`duty_hi_i`, `duty_lo_i`}, with the 8-bit part in bits 10..3 and the 3-bit part in bits 2..0. The high-side request is active while count < duty, and the low-side request is active otherwise.
- R4: A `duty_wr_i` pulse captures the duty inputs into a shadow register. The captured value is applied when the next carrier period starts and not before.
- R5: `period_start_o` is high for one clock at the start of every carrier period. A period starts when the count returns to 0 in modes 0, 2 and 3, and when it reloads P in mode 1. The pulse is high in the same clock as the new count.
- R6: `adc_trig_o` is a one-clock pulse. With `trig_valley_i`=0 it fires when the count reaches P (the peak). With `trig_valley_i`=1 it fires when the count reaches 0 (the valley). It fires once per carrier period.
- R7: Each output rises `deadtime_i` clocks after the one-clock registration of its request, and it falls one clock after its request drops. `pwm_hi_o` and `pwm_lo_o` are never high together.
- R8: If `oc_hi_i`, `oc_lo_i` or `short_i` is high, both outputs are low from the next clock until the clock in which `period_start_o` is high. After that, normal operation resumes.
- R9: `short_i` sets `fault_o` on the next clock. `fault_o` stays set until a `fault_clr_i` pulse clears it. `oc_hi_i` and `oc_lo_i` leave `fault_o` unchanged.
- R10: While `rst_n` is low, `pwm_hi_o`, `pwm_lo_o`, `period_start_o`, `adc_trig_o` and `fault_o` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_i | input | 2 | Carrier shape select |
| period_i | input | 11 | Carrier period value P |
| prescale_i | input | 8 | Clocks per counter step, minus one |
| duty_hi_i | input | 8 | Upper 8 bits of the duty value |
| duty_lo_i | input | 3 | Lower 3 bits of the duty value |
| duty_wr_i | input | 1 | Strobe that captures the duty value into the shadow register |
| deadtime_i | input | 8 | Rising-edge delay in clocks |
| trig_valley_i | input | 1 | ADC trigger at the valley (1) or at the peak (0) |
| oc_hi_i | input | 1 | Positive over-current comparator |
| oc_lo_i | input | 1 | Negative over-current comparator |
| short_i | input | 1 | Short-circuit comparator |
| fault_clr_i | input | 1 | Clears the sticky fault flag |
| pwm_hi_o | output | 1 | High-side gate drive |
| pwm_lo_o | output | 1 | Low-side gate drive |
| period_start_o | output | 1 | Period-start strobe |
| adc_trig_o | output | 1 | ADC trigger pulse |
| fault_o | output | 1 | Sticky short-circuit flag |

## Verification
The period-start assertion assumes that a carrier period lasts at least two clocks, which means P is at least 1 and the mode and period stay constant outside reset. The bench changes mode, period, prescaler and dead time only while reset is held, and always uses P of at least 4. The blanking and fault assertions assume that the comparator and clear inputs change only between clock edges. The bench drives every input on the falling edge, and it pulses the over-current inputs in the middle of a period, well away from a period start.

// File: rtl/pwm_cbc_pkg.sv
package pwm_cbc_pkg;

    typedef enum logic [1:0] {
        CARRIER_RISE = 2'd0,
        CARRIER_FALL = 2'd1,
        CARRIER_TRI  = 2'd2,
        CARRIER_ALT  = 2'd3
    } carrier_mode_e;

    localparam int SIDE_HI = 0;
    localparam int SIDE_LO = 1;
    localparam int NUM_SIDES = 2;

endpackage

// File: rtl/pwm_carrier_cnt.sv
module pwm_carrier_cnt
    import pwm_cbc_pkg::*;
#(
    parameter int CNT_W = 11,
    parameter int PRE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       mode_i,
    input  logic [CNT_W-1:0] period_i,
    input  logic [PRE_W-1:0] prescale_i,
    input  logic             trig_valley_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             start_nxt_o,
    output logic             start_o,
    output logic             trig_o
);

    typedef struct packed {
        logic [PRE_W-1:0] pre;
        logic [CNT_W-1:0] cnt;
        logic             dir_up;
        logic             start;
        logic             trig;
    } cnt_state_t;

    cnt_state_t s_d, s_q;
    carrier_mode_e mode;
    logic tick;
    logic start_nxt;

    assign mode = carrier_mode_e'(mode_i);

    always_comb begin
        s_d       = s_q;
        s_d.start = 1'b0;
        s_d.trig  = 1'b0;
        start_nxt = 1'b0;
        tick      = (s_q.pre >= prescale_i);
        s_d.pre   = tick ? '0 : s_q.pre + 1'b1;
        if (tick) begin
            unique case (mode)
                CARRIER_FALL: begin
                    if (s_q.cnt == '0 || s_q.cnt > period_i) s_d.cnt = period_i;
                    else s_d.cnt = s_q.cnt - 1'b1;
                    start_nxt = (s_d.cnt == period_i);
                end
                CARRIER_TRI: begin
                    if (s_q.dir_up) begin
                        if (s_q.cnt >= period_i) begin
                            s_d.cnt    = s_q.cnt - 1'b1;
                            s_d.dir_up = 1'b0;
                        end else begin
                            s_d.cnt = s_q.cnt + 1'b1;
                        end
                    end else if (s_q.cnt <= 1) begin
                        s_d.cnt    = '0;
                        s_d.dir_up = 1'b1;
                    end else begin
                        s_d.cnt = s_q.cnt - 1'b1;
                    end
                    if (s_d.cnt == '0) s_d.dir_up = 1'b1;
                    start_nxt = (s_d.cnt == '0);
                end
                default: begin
                    s_d.cnt   = (s_q.cnt >= period_i) ? '0 : s_q.cnt + 1'b1;
                    start_nxt = (s_d.cnt == '0);
                end
            endcase
            s_d.start = start_nxt;
            s_d.trig  = trig_valley_i ? (s_d.cnt == '0) : (s_d.cnt == period_i);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q        <= '0;
            s_q.dir_up <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign cnt_o       = s_q.cnt;
    assign start_nxt_o = start_nxt;
    assign start_o     = s_q.start;
    assign trig_o      = s_q.trig;

endmodule

// File: rtl/pwm_deadband.sv
module pwm_deadband #(
    parameter int DT_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_i,
    input  logic [DT_W-1:0] dt_i,
    output logic            out_o
);

    typedef struct packed {
        logic [DT_W-1:0] wait_cnt;
        logic            drive;
    } db_state_t;

    db_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (!req_i) begin
            s_d.drive    = 1'b0;
            s_d.wait_cnt = '0;
        end else if (!s_q.drive) begin
            if (s_q.wait_cnt >= dt_i) s_d.drive = 1'b1;
            else s_d.wait_cnt = s_q.wait_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign out_o = s_q.drive;

endmodule

// File: rtl/pwm_carrier_cbc.sv
module pwm_carrier_cbc
    import pwm_cbc_pkg::*;
#(
    parameter int DUTY_HI_W = 8,
    parameter int DUTY_LO_W = 3,
    parameter int PRE_W     = 8,
    parameter int DT_W      = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [1:0]                     mode_i,
    input  logic [DUTY_HI_W+DUTY_LO_W-1:0] period_i,
    input  logic [PRE_W-1:0]               prescale_i,
    input  logic [DUTY_HI_W-1:0]           duty_hi_i,
    input  logic [DUTY_LO_W-1:0]           duty_lo_i,
    input  logic                           duty_wr_i,
    input  logic [DT_W-1:0]                deadtime_i,
    input  logic                           trig_valley_i,
    input  logic                           oc_hi_i,
    input  logic                           oc_lo_i,
    input  logic                           short_i,
    input  logic                           fault_clr_i,
    output logic                           pwm_hi_o,
    output logic                           pwm_lo_o,
    output logic                           period_start_o,
    output logic                           adc_trig_o,
    output logic                           fault_o
);

    localparam int DUTY_W = DUTY_HI_W + DUTY_LO_W;

    typedef struct packed {
        logic [DUTY_W-1:0] duty_pend;
        logic [DUTY_W-1:0] duty_act;
        logic              blank;
        logic              fault;
    } top_state_t;

    top_state_t s_d, s_q;
    logic [DUTY_W-1:0] cnt;
    logic              start_nxt;
    logic              oc_any;
    logic              below;
    logic [NUM_SIDES-1:0] side_req;
    logic [NUM_SIDES-1:0] side_out;

    pwm_carrier_cnt #(
        .CNT_W (DUTY_W),
        .PRE_W (PRE_W)
    ) u_cnt (
        .clk           (clk),
        .rst_n         (rst_n),
        .mode_i        (mode_i),
        .period_i      (period_i),
        .prescale_i    (prescale_i),
        .trig_valley_i (trig_valley_i),
        .cnt_o         (cnt),
        .start_nxt_o   (start_nxt),
        .start_o       (period_start_o),
        .trig_o        (adc_trig_o)
    );

    assign oc_any = oc_hi_i | oc_lo_i | short_i;

    always_comb begin
        s_d = s_q;
        if (duty_wr_i) s_d.duty_pend = {duty_hi_i, duty_lo_i};
        if (start_nxt) s_d.duty_act = s_q.duty_pend;
        if (oc_any)         s_d.blank = 1'b1;
        else if (start_nxt) s_d.blank = 1'b0;
        if (short_i)          s_d.fault = 1'b1;
        else if (fault_clr_i) s_d.fault = 1'b0;

        below             = (cnt < s_q.duty_act);
        side_req[SIDE_HI] = below  & ~s_q.blank & ~oc_any;
        side_req[SIDE_LO] = ~below & ~s_q.blank & ~oc_any;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    for (genvar g = 0; g < NUM_SIDES; g++) begin : g_side
        pwm_deadband #(
            .DT_W (DT_W)
        ) u_db (
            .clk   (clk),
            .rst_n (rst_n),
            .req_i (side_req[g]),
            .dt_i  (deadtime_i),
            .out_o (side_out[g])
        );
    end

    assign pwm_hi_o = side_out[SIDE_HI];
    assign pwm_lo_o = side_out[SIDE_LO];
    assign fault_o  = s_q.fault;

endmodule

// File: rtl/pwm_carrier_cbc_chk.sv
module pwm_carrier_cbc_chk (
    input logic clk,
    input logic rst_n,
    input logic hi,
    input logic lo,
    input logic oc_hi,
    input logic oc_lo,
    input logic short_in,
    input logic fault_clr,
    input logic fault,
    input logic start
);

    a_r7_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(hi && lo));

    a_r8_oc_blank: assert property (@(posedge clk) disable iff (!rst_n)
        (oc_hi || oc_lo || short_in) |=> (!hi && !lo));

    a_r9_fault_set: assert property (@(posedge clk) disable iff (!rst_n)
        short_in |=> fault);

    a_r9_fault_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault) |-> $past(short_in));

    a_r9_fault_fall_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fault) |-> $past(fault_clr));

    a_r5_start_single: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !start);

endmodule

bind pwm_carrier_cbc pwm_carrier_cbc_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .hi        (pwm_hi_o),
    .lo        (pwm_lo_o),
    .oc_hi     (oc_hi_i),
    .oc_lo     (oc_lo_i),
    .short_in  (short_i),
    .fault_clr (fault_clr_i),
    .fault     (fault_o),
    .start     (period_start_o)
);

// File: tb/tb_pwm_carrier_cbc.sv
module tb_pwm_carrier_cbc;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  mode_i = '0;
    logic [10:0] period_i = 11'd9;
    logic [7:0]  prescale_i = '0;
    logic [7:0]  duty_hi_i = '0;
    logic [2:0]  duty_lo_i = '0;
    logic        duty_wr_i = 1'b0;
    logic [7:0]  deadtime_i = '0;
    logic        trig_valley_i = 1'b0;
    logic        oc_hi_i = 1'b0;
    logic        oc_lo_i = 1'b0;
    logic        short_i = 1'b0;
    logic        fault_clr_i = 1'b0;
    logic        pwm_hi_o, pwm_lo_o, period_start_o, adc_trig_o, fault_o;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwm_carrier_cbc dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .mode_i         (mode_i),
        .period_i       (period_i),
        .prescale_i     (prescale_i),
        .duty_hi_i      (duty_hi_i),
        .duty_lo_i      (duty_lo_i),
        .duty_wr_i      (duty_wr_i),
        .deadtime_i     (deadtime_i),
        .trig_valley_i  (trig_valley_i),
        .oc_hi_i        (oc_hi_i),
        .oc_lo_i        (oc_lo_i),
        .short_i        (short_i),
        .fault_clr_i    (fault_clr_i),
        .pwm_hi_o       (pwm_hi_o),
        .pwm_lo_o       (pwm_lo_o),
        .period_start_o (period_start_o),
        .adc_trig_o     (adc_trig_o),
        .fault_o        (fault_o)
    );

    task automatic step();
        @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Configuration changes only under reset; R10 is checked every time.
    task automatic setup(input int mode, input int per, input int pre, input int dt,
                         input bit valley, input int dhi, input int dlo);
        step();
        rst_n = 1'b0;
        mode_i = mode[1:0];
        period_i = per[10:0];
        prescale_i = pre[7:0];
        deadtime_i = dt[7:0];
        trig_valley_i = valley;
        oc_hi_i = 1'b0; oc_lo_i = 1'b0; short_i = 1'b0;
        fault_clr_i = 1'b0; duty_wr_i = 1'b0;
        repeat (3) step();
        check(!pwm_hi_o && !pwm_lo_o && !period_start_o && !adc_trig_o && !fault_o,
              "R10 reset outputs",
              int'({pwm_hi_o, pwm_lo_o, period_start_o, adc_trig_o, fault_o}), 0);
        rst_n = 1'b1;
        step();
        duty_hi_i = dhi[7:0];
        duty_lo_i = dlo[2:0];
        duty_wr_i = 1'b1;
        step();
        duty_wr_i = 1'b0;
    endtask

    task automatic wait_start();
        int guard = 0;
        step();
        while (!period_start_o && guard < 5000) begin
            step();
            guard++;
        end
        if (guard >= 5000) check(1'b0, "R5 no period start", 0, 1);
    endtask

    task automatic count_window(input int len, output int hc, output int lc, output int both);
        hc = 0; lc = 0; both = 0;
        for (int i = 0; i < len; i++) begin
            hc += int'(pwm_hi_o);
            lc += int'(pwm_lo_o);
            both += int'(pwm_hi_o && pwm_lo_o);
            step();
            duty_wr_i = 1'b0;
        end
    endtask

    task automatic measure_period(input int mode, input int per, input int pre,
                                  input int exp, input string req);
        int n = 0;
        setup(mode, per, pre, 0, 1'b0, 0, 2);
        wait_start();
        step();
        check(!period_start_o, "R5 strobe one clock wide", int'(period_start_o), 0);
        n = 1;
        while (!period_start_o && n < 5000) begin
            step();
            n++;
        end
        check(n == exp, req, n, exp);
    endtask

    task automatic test_periods();
        measure_period(0, 9, 0, 10, "R1 rising sawtooth period");
        measure_period(1, 9, 0, 10, "R1 falling sawtooth period");
        measure_period(2, 9, 0, 18, "R1 triangle period");
        measure_period(3, 9, 0, 10, "R1 mode 3 acts as rising");
        measure_period(0, 9, 1, 20, "R2 prescale 1 doubles period");
    endtask

    task automatic duty_case(input int mode, input int per, input int pre, input int dt,
                             input int dhi, input int dlo, input int len,
                             input int exp_hi, input int exp_lo, input string req);
        int hc, lc, both;
        setup(mode, per, pre, dt, 1'b0, dhi, dlo);
        wait_start();
        wait_start();
        count_window(len, hc, lc, both);
        check(hc == exp_hi, {req, " high-side clocks"}, hc, exp_hi);
        check(lc == exp_lo, {req, " low-side clocks"}, lc, exp_lo);
        check(both == 0, "R7 outputs never both high", both, 0);
    endtask

    task automatic test_duty();
        duty_case(0, 9, 0, 0, 0, 4, 10, 4, 6, "R3 rising duty 4");
        duty_case(0, 19, 0, 0, 1, 1, 20, 9, 11, "R3 duty from both fields (9)");
        duty_case(2, 8, 0, 0, 0, 3, 16, 5, 11, "R3 triangle duty 3");
        duty_case(1, 9, 0, 1, 0, 4, 10, 3, 5, "R7 falling duty 4 dead time 1");
        duty_case(0, 9, 0, 2, 0, 4, 10, 2, 4, "R7 rising duty 4 dead time 2");
        duty_case(0, 4, 2, 0, 0, 2, 15, 6, 9, "R2 prescale 2 duty 2");
    endtask

    task automatic test_shadow();
        int hc, lc, both;
        setup(0, 9, 0, 0, 1'b0, 0, 4);
        wait_start();
        wait_start();
        duty_lo_i = 3'd7;
        duty_wr_i = 1'b1;
        count_window(10, hc, lc, both);
        check(hc == 4, "R4 write held until next period", hc, 4);
        count_window(10, hc, lc, both);
        check(hc == 7, "R4 write applied at period start", hc, 7);
    endtask

    task automatic test_trigger();
        int n = 0;
        int pulses = 0;
        setup(2, 8, 0, 0, 1'b0, 0, 3);
        wait_start();
        wait_start();
        check(!adc_trig_o, "R6 peak trigger absent at valley", int'(adc_trig_o), 0);
        while (!adc_trig_o && n < 100) begin
            step();
            n++;
        end
        check(n == 8, "R6 peak trigger clocks after start", n, 8);
        setup(2, 8, 0, 0, 1'b1, 0, 3);
        wait_start();
        wait_start();
        check(adc_trig_o, "R6 valley trigger with start", int'(adc_trig_o), 1);
        for (int i = 0; i < 16; i++) begin
            pulses += int'(adc_trig_o);
            step();
        end
        check(pulses == 1, "R6 one trigger per period", pulses, 1);
    endtask

    task automatic test_overcurrent(input int which);
        int viol = 0;
        int guard = 0;
        setup(0, 19, 0, 0, 1'b0, 1, 2);
        wait_start();
        wait_start();
        repeat (3) step();
        check(pwm_hi_o, "R3 high side on before event", int'(pwm_hi_o), 1);
        if (which == 0) oc_hi_i = 1'b1;
        else if (which == 1) oc_lo_i = 1'b1;
        else short_i = 1'b1;
        step();
        oc_hi_i = 1'b0; oc_lo_i = 1'b0; short_i = 1'b0;
        check(!pwm_hi_o && !pwm_lo_o, "R8 outputs off next clock",
              int'({pwm_hi_o, pwm_lo_o}), 0);
        if (which == 2) check(fault_o, "R9 short sets fault", int'(fault_o), 1);
        else check(!fault_o, "R9 over-current leaves fault clear", int'(fault_o), 0);
        while (!period_start_o && guard < 100) begin
            viol += int'(pwm_hi_o || pwm_lo_o);
            step();
            guard++;
        end
        viol += int'(pwm_hi_o || pwm_lo_o);
        check(viol == 0 && guard < 100, "R8 off until period start", viol, 0);
        step();
        check(pwm_hi_o, "R8 resumes after period start", int'(pwm_hi_o), 1);
        if (which == 2) begin
            check(fault_o, "R9 fault held across period", int'(fault_o), 1);
            fault_clr_i = 1'b1;
            step();
            fault_clr_i = 1'b0;
            check(!fault_o, "R9 fault cleared", int'(fault_o), 0);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=0 expected=1");
            summary();
            $finish;
        end
    end

    initial begin
        test_periods();
        test_duty();
        test_shadow();
        test_trigger();
        test_overcurrent(0);
        test_overcurrent(1);
        test_overcurrent(2);
        if (!finished) begin
            finished = 1'b1;
            summary();
            $finish;
        end
    end

endmodule